// File: doc/BRIEF.md
# Latched Channel-Select Decoder with Break-Before-Make

This block drives the enable lines of a sixteen-way switch bank from a four-bit channel number, an enable bit, an active-low write strobe and an active-low clear. All four control inputs are taken into the system clock domain through two-flop synchronizers. The synchronized channel number and enable then pass through holding registers. These registers are transparent while the strobe is low and frozen while it is high. The held values are decoded to a one-hot switch-enable vector.

Every move from one channel to another goes through an all-off gap of `DEAD_CYCLES` clock cycles, so two channels are never on together. A `busy_o` flag is high for the whole gap. Turning the enable off acts at once and has no gap. A build-time option `DIFF` gives a paired variant: the low three address bits select one of eight pairs, and both members of the chosen pair switch together.

The control pins are plain level signals with no handshake. A host writes by pulling `wr_n_i` low, setting the channel and enable, and raising the strobe. The values in force when the synchronized strobe goes high are kept until the next write.

Top module: `chan_sel_bbm`

## Requirements
- R1: In single mode, a held enable of 1 with held channel number `a` (bit 3 is the MSB) leaves only `sw_en_o[a]` high once the dead time is over, so `0000` drives bit 0 and `1111` drives bit 15.
- R2: When the held enable is 0, `sw_en_o` is all zeros for every channel number.
- R3: While `wr_n_i` is low, the held channel and enable follow the input pins, so the output tracks each new channel.
- R4: While `wr_n_i` is high, the held state does not change whatever the pins do. The values present in the last cycle before the synchronized strobe rose are the ones kept, including when the channel pins change on the same edge as the strobe.
- R5: Pulling `clr_n_i` low forces `sw_en_o` to zero and `busy_o` low at once, without waiting for a clock edge, and clears the held channel and enable. After release, the output stays off until a new write occurs.
- R6: A change between two enabled channels first drives `sw_en_o` to zero. It then holds the output at zero, with `busy_o` high, for exactly `DEAD_CYCLES` cycles before the new channel turns on. A nonzero output never changes directly into a different nonzero output.
- R7: If the held selection changes again while `busy_o` is high, the dead-time count starts over, and only the latest selection is applied when it runs out.
- R8: A change of the held enable from 1 to 0 clears the output in the next cycle with no busy period. A change from 0 to 1 turns the selected channel on after one full dead-time interval.
- R9: With `DIFF=1`, channel-number bit 3 is ignored, and pair `k` (bits 2..0) drives `sw_en_o[k]` and `sw_en_o[k+8]` high together.
- R10: A change on the pins reaches the decoder four rising clock edges after it is applied: two synchronizer stages, the holding register and the output register.
- R11: `sw_en_o` never has more than one channel (single mode) or one pair (paired mode) high, and it is all zeros whenever `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n_i | input | 1 | Active-low clear. Asserts asynchronously and is released in step with `clk` |
| addr_i | input | 4 | Channel number, bit 3 the MSB |
| en_i | input | 1 | Channel enable; 0 turns all switches off |
| wr_n_i | input | 1 | Active-low write strobe; the holding registers are transparent while it is low |
| sw_en_o | output | 16 | One-hot switch enables; in paired mode, bits k and k+8 form pair k |
| busy_o | output | 1 | High during the break-before-make dead time |

## Verification
The bench changes the pins on the falling clock edge and counts rising edges before it samples. A new selection shows `busy_o` high with zero outputs after the fourth rising edge. The new channel appears after edge 4+`DEAD_CYCLES`, and a dead-time restart moves that to edge 5+`DEAD_CYCLES`. Clearing the enable empties the output after exactly four edges. The clear input is checked one nanosecond after it falls, with no clock edge in between. Each check also samples one edge early where that separates a correct design from one with an off-by-one latency.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Sequencer phase: steady output or break-before-make gap.
  typedef enum logic {
    SEQ_STEADY = 1'b0,
    SEQ_DEAD   = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cs_sync.sv
// Two-flop synchronizer for a bus of independent level inputs.
module cs_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1, stg2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= RST_VAL;
      stg2 <= RST_VAL;
    end else begin
      stg1 <= d_i;
      stg2 <= stg1;
    end
  end

  assign q_o = stg2;
endmodule

// File: rtl/cs_rst_sync.sv
// Asynchronous assert, synchronous release of the clear input.
module cs_rst_sync (
  input  logic clk,
  input  logic clr_n_i,
  output logic rst_n_o
);
  logic r1, r2;

  always_ff @(posedge clk or negedge clr_n_i) begin
    if (!clr_n_i) begin
      r1 <= 1'b0;
      r2 <= 1'b0;
    end else begin
      r1 <= 1'b1;
      r2 <= r1;
    end
  end

  assign rst_n_o = r2;
endmodule

// File: rtl/cs_hold_latch.sv
// Holding registers: transparent while the strobe is low, frozen while high.
module cs_hold_latch #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic              en_s,
  output logic [ADDR_W-1:0] addr_q,
  output logic              en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (!wr_n_s) begin
      addr_q <= addr_s;
      en_q   <= en_s;
    end
  end
endmodule

// File: rtl/cs_decode.sv
// Channel number to switch-enable vector, single or paired.
module cs_decode #(
  parameter int ADDR_W = 4,
  parameter bit DIFF   = 1'b0
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     en_i,
  output logic [(1<<ADDR_W)-1:0]   onehot_o
);
  localparam int NUM_OUT = 1 << ADDR_W;
  localparam int PAIRS   = NUM_OUT / 2;

  generate
    if (DIFF) begin : g_pair
      for (genvar k = 0; k < PAIRS; k++) begin : g_bit
        assign onehot_o[k]         = en_i && (addr_i[ADDR_W-2:0] == (ADDR_W-1)'(k));
        assign onehot_o[k + PAIRS] = en_i && (addr_i[ADDR_W-2:0] == (ADDR_W-1)'(k));
      end
    end else begin : g_single
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_bit
        assign onehot_o[k] = en_i && (addr_i == ADDR_W'(k));
      end
    end
  endgenerate
endmodule

// File: rtl/cs_bbm_seq.sv
// Break-before-make sequencer with restartable dead time.
module cs_bbm_seq
  import cs_pkg::*;
#(
  parameter int NUM_OUT     = 16,
  parameter int DEAD_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] target_i,
  output logic [NUM_OUT-1:0] sw_o,
  output logic               busy_o
);
  localparam int CNT_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES - 1);

  seq_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_OUT-1:0] pend;
  logic [NUM_OUT-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_STEADY;
      cnt   <= '0;
      pend  <= '0;
      cur   <= '0;
    end else if (target_i == '0) begin
      // Disable: off at once, no gap.
      state <= SEQ_STEADY;
      cnt   <= '0;
      cur   <= '0;
    end else if (state == SEQ_DEAD) begin
      if (target_i != pend) begin
        pend <= target_i;
        cnt  <= CNT_LOAD;
      end else if (cnt == '0) begin
        cur   <= pend;
        state <= SEQ_STEADY;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (target_i != cur) begin
      cur   <= '0;
      pend  <= target_i;
      cnt   <= CNT_LOAD;
      state <= SEQ_DEAD;
    end
  end

  assign sw_o   = cur;
  assign busy_o = (state == SEQ_DEAD);
endmodule

// File: rtl/chan_sel_bbm.sv
module chan_sel_bbm #(
  parameter int ADDR_W      = 4,
  parameter bit DIFF        = 1'b0,
  parameter int DEAD_CYCLES = 2
) (
  input  logic                     clk,
  input  logic                     clr_n_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     en_i,
  input  logic                     wr_n_i,
  output logic [(1<<ADDR_W)-1:0]   sw_en_o,
  output logic                     busy_o
);
  localparam int NUM_OUT = 1 << ADDR_W;
  localparam int SYNC_W  = ADDR_W + 2;

  logic               rst_n_q;
  logic [SYNC_W-1:0]  sync_q;
  logic [ADDR_W-1:0]  addr_s;
  logic               en_s;
  logic               wr_n_s;
  logic [ADDR_W-1:0]  lat_addr;
  logic               lat_en;
  logic [NUM_OUT-1:0] target;

  cs_rst_sync u_rst (
    .clk     (clk),
    .clr_n_i (clr_n_i),
    .rst_n_o (rst_n_q)
  );

  // Strobe resets high (hold), data resets low.
  cs_sync #(
    .W       (SYNC_W),
    .RST_VAL ({1'b1, {(SYNC_W-1){1'b0}}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_q),
    .d_i   ({wr_n_i, en_i, addr_i}),
    .q_o   (sync_q)
  );

  assign addr_s = sync_q[ADDR_W-1:0];
  assign en_s   = sync_q[ADDR_W];
  assign wr_n_s = sync_q[ADDR_W+1];

  cs_hold_latch #(.ADDR_W(ADDR_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_q),
    .wr_n_s (wr_n_s),
    .addr_s (addr_s),
    .en_s   (en_s),
    .addr_q (lat_addr),
    .en_q   (lat_en)
  );

  cs_decode #(.ADDR_W(ADDR_W), .DIFF(DIFF)) u_dec (
    .addr_i   (lat_addr),
    .en_i     (lat_en),
    .onehot_o (target)
  );

  cs_bbm_seq #(.NUM_OUT(NUM_OUT), .DEAD_CYCLES(DEAD_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .target_i (target),
    .sw_o     (sw_en_o),
    .busy_o   (busy_o)
  );
endmodule

// File: rtl/chan_sel_bbm_chk.sv
module chan_sel_bbm_chk #(
  parameter int NUM_OUT = 16,
  parameter bit DIFF    = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lat_en,
  input logic [NUM_OUT-1:0] sw_en_o,
  input logic               busy_o
);
  localparam int ON_CNT = DIFF ? 2 : 1;

  // R11: at most one channel or pair on
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_en_o) == 0) || ($countones(sw_en_o) == ON_CNT));

  // R11: outputs dark while busy
  p_dark_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (sw_en_o == '0));

  // R6: no direct channel-to-channel move
  p_bbm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_en_o != '0) && ($past(sw_en_o) != '0)) |-> (sw_en_o == $past(sw_en_o)));

  // R6: a new channel only comes on out of a busy gap
  p_on_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_en_o != '0) && ($past(sw_en_o) == '0)) |-> $fell(busy_o));

  // R2: held enable low clears output next cycle
  p_disabled_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_en |=> (sw_en_o == '0));

  // R5: held in clear means all off
  p_clear_off_r5: assert property (@(posedge clk)
    !rst_n |-> ((sw_en_o == '0) && !busy_o));
endmodule

bind chan_sel_bbm chan_sel_bbm_chk #(.NUM_OUT(NUM_OUT), .DIFF(DIFF)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_q),
  .lat_en  (lat_en),
  .sw_en_o (sw_en_o),
  .busy_o  (busy_o)
);

// File: tb/chan_sel_bbm_tb.sv
`timescale 1ns/1ps
module chan_sel_bbm_tb;
  localparam int DEAD = 2;

  logic        clk = 1'b0;
  logic        clr_n;
  logic [3:0]  addr;
  logic        en;
  logic        wr_n;
  logic [15:0] sw, sw_d;
  logic        busy, busy_d;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  chan_sel_bbm #(.ADDR_W(4), .DIFF(1'b0), .DEAD_CYCLES(DEAD)) u_dut (
    .clk(clk), .clr_n_i(clr_n), .addr_i(addr), .en_i(en), .wr_n_i(wr_n),
    .sw_en_o(sw), .busy_o(busy)
  );

  chan_sel_bbm #(.ADDR_W(4), .DIFF(1'b1), .DEAD_CYCLES(DEAD)) u_dut_d (
    .clk(clk), .clr_n_i(clr_n), .addr_i(addr), .en_i(en), .wr_n_i(wr_n),
    .sw_en_o(sw_d), .busy_o(busy_d)
  );

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Wait n rising edges, then sit on the falling edge.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    step(3);
    chk("R5 reset single", {busy, sw}, 17'h0);
    chk("R5 reset paired", {busy_d, sw_d}, 17'h0);
    clr_n = 1'b1;
    step(4);
  endtask

  task automatic t_select;
    wr_n = 1'b0; en = 1'b1; addr = 4'd0;
    step(3);
    chk("R10 not yet visible", {busy, sw}, 17'h0);
    step(1);
    chk("R6 gap starts", {busy, sw}, {1'b1, 16'h0});
    step(DEAD);
    chk("R1 channel 0 on", {busy, sw}, {1'b0, 16'h0001});
    addr = 4'd15;
    step(4);
    chk("R6 old channel dropped", {busy, sw}, {1'b1, 16'h0});
    step(DEAD - 1);
    chk("R6 still in gap", {busy, sw}, {1'b1, 16'h0});
    step(1);
    chk("R3 R1 channel 15 on", {busy, sw}, {1'b0, 16'h8000});
  endtask

  task automatic t_enable;
    en = 1'b0;
    step(3);
    chk("R8 off not early", {busy, sw}, {1'b0, 16'h8000});
    step(1);
    chk("R8 immediate off", {busy, sw}, 17'h0);
    addr = 4'd6;
    step(8);
    chk("R2 disabled any address", {busy, sw}, 17'h0);
    en = 1'b1;
    step(4);
    chk("R8 enable gap", {busy, sw}, {1'b1, 16'h0});
    step(DEAD);
    chk("R8 channel 6 on", {busy, sw}, {1'b0, 16'h0040});
  endtask

  task automatic t_hold;
    addr = 4'd5;
    step(4 + DEAD);
    chk("R3 channel 5 on", {busy, sw}, {1'b0, 16'h0020});
    wr_n = 1'b1; addr = 4'd9;
    step(10);
    chk("R4 captured before rise", {busy, sw}, {1'b0, 16'h0020});
    en = 1'b0; addr = 4'd2;
    step(10);
    chk("R4 pins ignored", {busy, sw}, {1'b0, 16'h0020});
    en = 1'b1;
  endtask

  task automatic t_restart;
    addr = 4'd3; wr_n = 1'b0;
    step(4 + DEAD + 2);
    chk("R1 channel 3 on", {busy, sw}, {1'b0, 16'h0008});
    addr = 4'd7;
    step(1);
    addr = 4'd9;
    step(4 + DEAD - 1);
    chk("R7 gap restarted", {busy, sw}, {1'b1, 16'h0});
    step(1);
    chk("R7 latest applied", {busy, sw}, {1'b0, 16'h0200});
  endtask

  task automatic t_clear;
    #1 clr_n = 1'b0;
    #1;
    chk("R5 async off", {busy, sw}, 17'h0);
    @(negedge clk);
    wr_n = 1'b1; addr = 4'd4;
    step(2);
    clr_n = 1'b1;
    step(10);
    chk("R5 latches cleared", {busy, sw}, 17'h0);
    wr_n = 1'b0;
    step(4 + DEAD);
    chk("R5 rewrite after clear", {busy, sw}, {1'b0, 16'h0010});
  endtask

  task automatic t_paired;
    addr = 4'b1101;
    step(4 + DEAD + 2);
    chk("R9 pair 5 both on", {busy_d, sw_d}, {1'b0, 16'h2020});
    chk("R1 single channel 13", {busy, sw}, {1'b0, 16'h2000});
    addr = 4'b0101;
    step(4 + DEAD + 2);
    chk("R9 bit 3 ignored", {busy_d, sw_d}, {1'b0, 16'h2020});
    chk("R1 single channel 5", {busy, sw}, {1'b0, 16'h0020});
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr_n = 1'b0; wr_n = 1'b1; en = 1'b0; addr = 4'd0;
    @(negedge clk);
    t_reset_state();
    t_select();
    t_enable();
    t_hold();
    t_restart();
    t_clear();
    t_paired();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule